// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block performs a single indivisible read-modify-write on a 64-bit wide synchronous memory port. A start pulse hands it an operation selector byte, an access size, a target address and two operand values: the source register value and the value of register zero, the implicit compare operand. The unit reads the addressed location, works out the replacement value and writes it back when the operation calls for that. It then returns the prior memory contents through one of two writeback strobes, one for the source register and one for register zero.

A lock output stays high from the read cycle through the write cycle. An arbiter in front of the memory uses it to keep every other requester off the port, so nothing can slip between the read and the write. The operation set covers add, or, and and xor, each with an optional fetch of the old value. It also covers an unconditional swap and a compare-and-swap. Any selector outside that set, or an access size narrower than a word, finishes at once with an error flag and never touches memory.

Top module: `amo_unit`

## Requirements
- R1: After reset the unit is idle: `mem_req`, `mem_lock`, `busy`, `done` and both writeback strobes are low.
- R2: A legal operation issues one read, then one write, with `mem_lock` high from the read cycle through the write cycle. `done` pulses for one cycle in the fourth cycle after the start pulse is sampled.
- R3: Selector values 0x00, 0x40, 0x50 and 0xa0 store old+src, old|src, old&src and old^src respectively. Addition wraps at the operation width.
- R4: Selector bit 0 is the fetch modifier. When it is set on add/or/and/xor, `src_wb_en` pulses with `done` and `wb_data` carries the old memory value. When it is clear, neither writeback strobe pulses.
- R5: Selector 0xe1 (swap) stores the source value and returns the old memory value on `src_wb_en`.
- R6: Selector 0xf1 (compare-and-swap) compares the old memory value with the register-zero operand. On equality it stores the source value. It returns the old value on `r0_wb_en`, never on `src_wb_en`.
- R7: On a compare-and-swap mismatch no write is issued, memory keeps its value, the old value still goes out on `r0_wb_en`, and `done` arrives one cycle earlier (third cycle after start).
- R8: Size code 3 selects a 64-bit access and size code 0 a 32-bit access (`mem_dw` high or low). A 32-bit operation uses only the low 32 bits of the source value, of the compare operand and of memory. The upper 32 bits of memory are left unchanged, and the returned value is zero-extended to 64 bits.
- R9: Any selector other than 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1, 0xf1, and any size code 1 or 2, sets `err` with `done` in the first cycle after start. No memory access is made and no writeback strobe pulses.
- R10: A start pulse that arrives while the unit is busy is ignored. It causes no extra memory access and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (sampled while idle) |
| size | input | 2 | Access size code: 0 word, 1 half, 2 byte, 3 double word |
| op_sel | input | 8 | Operation selector byte |
| addr | input | ADDR_W | Target address (base register plus offset) |
| src_val | input | DATA_W | Source register value |
| r0_val | input | DATA_W | Register-zero value, the compare operand |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable for the access |
| mem_dw | output | 1 | High for a 64-bit access, low for a 32-bit access |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| mem_lock | output | 1 | Exclusive hold on memory for the whole sequence |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported selector or size, valid with done |
| src_wb_en | output | 1 | Write wb_data to the source register |
| r0_wb_en | output | 1 | Write wb_data to register zero |
| wb_data | output | DATA_W | Old memory value, zero-extended for 32-bit operations |

## Verification
The bench sweeps all 256 selector values across all four size codes against a mirror memory, so any stray legal code or missed illegal code shows up. Illegal codes include 0xe0 and 0xf0, which lack the mandatory fetch bit. A unit that accepted those would write memory, and one that rejected 0x01 would drop the fetch result. Compare-and-swap runs alternately with matching and mismatching operands. A unit that wrote on mismatch would corrupt memory, and one that returned the value through the source strobe would be caught at the strobes. For 32-bit operations, memory upper halves are nonzero and compare operands differ only above bit 31. A design that compared or returned the full width would then mismatch or leak the upper bits. A start pulse driven mid-sequence checks that no second access is queued.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    AOP_ADD  = 3'd0,
    AOP_OR   = 3'd1,
    AOP_AND  = 3'd2,
    AOP_XOR  = 3'd3,
    AOP_SWAP = 3'd4,
    AOP_CAS  = 3'd5
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } amo_state_e;

  localparam logic [7:0] SEL_ADD  = 8'h00;
  localparam logic [7:0] SEL_OR   = 8'h40;
  localparam logic [7:0] SEL_AND  = 8'h50;
  localparam logic [7:0] SEL_XOR  = 8'ha0;
  localparam logic [7:0] SEL_SWAP = 8'he1;
  localparam logic [7:0] SEL_CAS  = 8'hf1;
  localparam logic [7:0] SEL_FETCH_BIT = 8'h01;

  localparam logic [1:0] SZ_WORD  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [7:0] sel,
  input  logic [1:0] size,
  output amo_op_e    op,
  output logic       fetch,
  output logic       dw,
  output logic       legal
);
  logic sel_ok;
  logic [7:0] base;

  always_comb begin
    base   = sel & ~SEL_FETCH_BIT;
    op     = AOP_ADD;
    sel_ok = 1'b1;
    fetch  = (sel & SEL_FETCH_BIT) != 8'h00;
    if (sel == SEL_SWAP) begin
      op = AOP_SWAP;
    end else if (sel == SEL_CAS) begin
      op = AOP_CAS;
    end else begin
      case (base)
        SEL_ADD: op = AOP_ADD;
        SEL_OR:  op = AOP_OR;
        SEL_AND: op = AOP_AND;
        SEL_XOR: op = AOP_XOR;
        default: sel_ok = 1'b0;
      endcase
    end
    dw    = (size == SZ_DWORD);
    legal = sel_ok && ((size == SZ_DWORD) || (size == SZ_WORD));
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op,
  input  logic              dw,
  input  logic [DATA_W-1:0] old_raw,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] cmp,
  output logic [DATA_W-1:0] old_ext,
  output logic [DATA_W-1:0] new_val,
  output logic              match
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] a, b, c, r;

  always_comb begin
    if (dw) begin
      a = old_raw;
      b = src;
      c = cmp;
    end else begin
      a = {{HALF{1'b0}}, old_raw[HALF-1:0]};
      b = {{HALF{1'b0}}, src[HALF-1:0]};
      c = {{HALF{1'b0}}, cmp[HALF-1:0]};
    end
    case (op)
      AOP_ADD:  r = a + b;
      AOP_OR:   r = a | b;
      AOP_AND:  r = a & b;
      AOP_XOR:  r = a ^ b;
      default:  r = b;
    endcase
    if (!dw) r[DATA_W-1:HALF] = '0;
    new_val = r;
    old_ext = a;
    match   = (a == c);
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       legal,
  input  logic       is_cas,
  input  logic       match,
  output amo_state_e state,
  output logic       accept,
  output logic       capture,
  output logic       reject
);
  amo_state_e state_d;

  always_comb begin
    state_d = state;
    accept  = 1'b0;
    capture = 1'b0;
    reject  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (legal) begin
            accept  = 1'b1;
            state_d = ST_READ;
          end else begin
            reject  = 1'b1;
            state_d = ST_DONE;
          end
        end
      end
      ST_READ:   state_d = ST_MODIFY;
      ST_MODIFY: begin
        capture = 1'b1;
        state_d = (is_cas && !match) ? ST_DONE : ST_WRITE;
      end
      ST_WRITE:  state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [7:0]        op_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] r0_val,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_dw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              src_wb_en,
  output logic              r0_wb_en,
  output logic [DATA_W-1:0] wb_data
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  amo_op_e    dec_op;
  logic       dec_fetch, dec_dw, dec_legal;
  amo_state_e state;
  logic       accept, capture, reject;

  amo_op_e           op_q;
  logic              fetch_q, dw_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
  logic [DATA_W-1:0] alu_old, alu_new;
  logic              alu_match;
  logic              is_cas_q;

  amo_decode u_dec (
    .sel   (op_sel),
    .size  (size),
    .op    (dec_op),
    .fetch (dec_fetch),
    .dw    (dec_dw),
    .legal (dec_legal)
  );

  assign is_cas_q = (op_q == AOP_CAS);

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .dw      (dw_q),
    .old_raw (mem_rdata),
    .src     (src_q),
    .cmp     (r0_q),
    .old_ext (alu_old),
    .new_val (alu_new),
    .match   (alu_match)
  );

  amo_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .legal   (dec_legal),
    .is_cas  (is_cas_q),
    .match   (alu_match),
    .state   (state),
    .accept  (accept),
    .capture (capture),
    .reject  (reject)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q    <= AOP_ADD;
      fetch_q <= 1'b0;
      dw_q    <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
    end else if (accept) begin
      op_q    <= dec_op;
      fetch_q <= dec_fetch;
      dw_q    <= dec_dw;
      addr_q  <= addr;
      src_q   <= src_val;
      r0_q    <= r0_val;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)            err_q <= 1'b0;
    else if (accept || reject) err_q <= reject;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      old_q <= '0;
      new_q <= '0;
    end else if (capture) begin
      old_q <= alu_old;
      new_q <= alu_new;
    end
  end

  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_lock  = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
  assign mem_dw    = dw_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign err       = done && err_q;
  assign src_wb_en = done && !err_q && fetch_q && !is_cas_q;
  assign r0_wb_en  = done && !err_q && is_cas_q;
  assign wb_data   = old_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_lock,
  input logic              done,
  input logic              err,
  input logic              src_wb_en,
  input logic              r0_wb_en,
  input logic              dw,
  input logic [DATA_W-1:0] wb_data
);
  localparam int HALF = DATA_W / 2;

  p_req_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_lock));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_lock_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> done);

  p_err_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !(src_wb_en || r0_wb_en));

  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_wb_en && r0_wb_en));

  p_word_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_wb_en || r0_wb_en) && !dw) |-> (wb_data[DATA_W-1:HALF] == '0));
endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_lock  (mem_lock),
  .done      (done),
  .err       (err),
  .src_wb_en (src_wb_en),
  .r0_wb_en  (r0_wb_en),
  .dw        (dw_q),
  .wb_data   (wb_data)
);

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;
  localparam int AW = 16;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    size;
  logic [7:0]    op_sel;
  logic [AW-1:0] addr;
  logic [DW-1:0] src_val, r0_val;
  logic          mem_req, mem_we, mem_dw, mem_lock, busy, done, err;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, wb_data;
  logic          src_wb_en, r0_wb_en;

  int checks = 0;
  int fails  = 0;
  int acc_cnt = 0;
  int cycles = 0;
  logic [DW-1:0] mem [16];
  logic [31:0] lfsr = 32'hace1_2468;

  always #4 clk = ~clk;

  amo_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size(size), .op_sel(op_sel),
    .addr(addr), .src_val(src_val), .r0_val(r0_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dw(mem_dw), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock),
    .busy(busy), .done(done), .err(err), .src_wb_en(src_wb_en),
    .r0_wb_en(r0_wb_en), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        if (mem_dw) mem[mem_addr[3:0]] <= mem_wdata;
        else        mem[mem_addr[3:0]][31:0] <= mem_wdata[31:0];
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic bit sel_legal(input logic [7:0] s);
    case (s)
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic [7:0] sel, input logic [3:0] ad,
                        input logic [DW-1:0] s, input logic [DW-1:0] r, input bit poke);
    logic [DW-1:0] old, a, b, c, nv, mem_exp, ret;
    bit legal, dwv, is_cas, match, do_write, exp_src, exp_r0;
    int lat, n, acc0;
    legal = sel_legal(sel) && (sz == 2'd0 || sz == 2'd3);
    dwv = (sz == 2'd3);
    old = mem[ad];
    a = dwv ? old : {32'h0, old[31:0]};
    b = dwv ? s   : {32'h0, s[31:0]};
    c = dwv ? r   : {32'h0, r[31:0]};
    is_cas = (sel == 8'hf1);
    match = (a == c);
    case (sel & 8'hfe)
      8'h00: nv = a + b;
      8'h40: nv = a | b;
      8'h50: nv = a & b;
      8'ha0: nv = a ^ b;
      default: nv = b;
    endcase
    do_write = legal && !(is_cas && !match);
    if (!do_write) mem_exp = old;
    else if (dwv)  mem_exp = nv;
    else           mem_exp = {old[63:32], nv[31:0]};
    exp_src = legal && !is_cas && sel[0];
    exp_r0  = legal && is_cas;
    ret = a;
    lat = !legal ? 1 : (do_write ? 4 : 3);

    @(negedge clk);
    start = 1'b1; size = sz; op_sel = sel; addr = {12'h0, ad}; src_val = s; r0_val = r;
    acc0 = acc_cnt;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (poke) begin
      start = 1'b1; op_sel = 8'h00; addr = {12'h0, ad + 4'd1}; size = 2'd3;
    end
    while (!done && n < 12) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) start = 1'b0;
    end
    check(legal ? (do_write ? "R2 latency" : "R7 latency") : "R9 latency", n, lat);
    check("R9 err flag", err, !legal);
    check(is_cas ? "R6 r0 strobe" : "R4 r0 strobe", r0_wb_en, exp_r0);
    check(is_cas ? "R6 src strobe" : "R4 src strobe", src_wb_en, exp_src);
    if (exp_src || exp_r0)
      check(dwv ? "R5 returned value" : "R8 returned value zext", wb_data, ret);
    @(negedge clk);
    check(is_cas ? "R7 memory after" : (dwv ? "R3 memory after" : "R8 memory after"),
          mem[ad], mem_exp);
    check("R9 access count", acc_cnt - acc0, !legal ? 0 : (do_write ? 2 : 1));
    check("R2 done single", done, 1'b0);
    if (poke) begin
      repeat (5) @(negedge clk);
      check("R10 no extra access", acc_cnt - acc0, 2);
      check("R10 idle after", busy, 1'b0);
    end
  endtask

  initial begin
    while (cycles < 190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] s, r;
    rst_n = 1'b0; start = 1'b0; size = 2'd0; op_sel = 8'h00; addr = '0;
    src_val = '0; r0_val = '0;
    for (int i = 0; i < 16; i++) mem[i] = {next_rand(), next_rand()};
    repeat (3) @(negedge clk);
    check("R1 req at reset", mem_req, 1'b0);
    check("R1 lock at reset", mem_lock, 1'b0);
    check("R1 done at reset", done, 1'b0);
    check("R1 busy at reset", busy, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after release", {busy, src_wb_en, r0_wb_en}, 3'b000);

    // R8 directed: word add wraps, upper half kept
    mem[2] = 64'h1234_5678_ffff_ffff;
    run_op(2'd0, 8'h01, 4'd2, 64'hdead_beef_0000_0001, 64'h0, 1'b0);
    check("R8 word wrap", mem[2], 64'h1234_5678_0000_0000);
    // R6 word compare ignores upper bits of r0
    mem[3] = 64'h5555_5555_0000_00aa;
    run_op(2'd0, 8'hf1, 4'd3, 64'h0000_0000_0000_0bbb, 64'hffff_ffff_0000_00aa, 1'b0);
    check("R6 word match write", mem[3], 64'h5555_5555_0000_0bbb);
    // R10 start during busy
    run_op(2'd3, 8'ha1, 4'd5, 64'h0f0f_0f0f_0f0f_0f0f, 64'h0, 1'b1);

    // sweep of all selectors and sizes
    for (int sel = 0; sel < 256; sel++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [3:0] ad;
        ad = 4'((sel * 4 + sz) % 16);
        s = {next_rand(), next_rand()};
        r = {next_rand(), next_rand()};
        if (((sel + sz) % 2) == 0) r = {r[63:32], mem[ad][31:0]} ^ ((sz == 3) ? (r ^ mem[ad]) & 64'hffff_ffff_0000_0000 : 64'h0);
        run_op(2'(sz), 8'(sel), ad, s, r, 1'b0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule